// File: doc/BRIEF.md
# Ethernet Receive Address Filter

The filter judges each received frame from its extracted header fields: destination address, source address, type field and the first payload word (the control opcode). It compares the two addresses with a bank of eight 48-bit station entries. Entry 0 is fixed as a destination entry. Entries 1 to 7 can each be enabled, assigned to the source or the destination role, and have chosen bytes masked out of the comparison. A mode word then turns the comparison results into a forward/drop decision and two status flags, one for a destination failure and one for a source failure.

The header fields are presented together with a one-cycle valid strobe. One clock later a registered decision appears with its own valid strobe. The mode word covers promiscuous and receive-all forwarding, inverse destination and inverse source matching, acceptance of all group addresses, broadcast blocking, source-filter enforcement and a four-way policy for control frames.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: `decValid` is high exactly one cycle after `hdrValid`. `forward`, `daFail` and `saFail` update only at that point and hold otherwise. After reset, all four outputs are 0.
- R2: With `promisc` set, and unless R6 applies, every frame is forwarded with `daFail` and `saFail` both 0.
- R3: Address byte k is bits [8k+7:8k], and byte 0 is sent first. Entry 0 is always enabled and compared against the destination. Entry i≥1 takes part when `entryEnable[i-1]` is 1. It is compared against the source when `entryIsSrc[i-1]` is 1 and against the destination when it is 0. Bit k of its 6-bit mask field `entryMask[6(i-1)+k]` excludes byte k from the comparison. In normal mode, a non-broadcast destination that matches no destination entry sets `daFail`.
- R4: With `inverseDa` set, a destination that matches a destination entry sets `daFail`, and a non-matching one passes. This applies to unicast and group addresses alike.
- R5: A destination whose group bit (bit 0) is 1 passes the destination filter when `passAllMulti` is set. The broadcast address (all ones) always passes the destination filter.
- R6: With `blockBcast` set, a broadcast frame is never forwarded. This overrides promiscuous mode, receive-all mode and the control policy.
- R7: When at least one source entry is enabled, `saFail` is set in normal mode if the source matches no source entry. With `inverseSa` set, it is set if the source does match. With no source entry enabled, `saFail` is 0.
- R8: With `saEnforce` set, a frame with `saFail` is dropped. With it clear, the frame is forwarded as far as the source is concerned, and only the flag is set.
- R9: With `receiveAll` set, and unless R6 applies, every frame is forwarded. `daFail` and `saFail` still report the real result.
- R10: A control frame has type 0x8808, and a pause frame is a control frame with opcode 0x0001. For control frames, `ctrlPolicy` works as follows. 00 drops them all. 01 forwards every control frame except pause frames, whatever the address result. 10 forwards all of them. 11 forwards only those that pass the address filter. Frames of any other type are unaffected by the policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hdrValid | input | 1 | Header fields valid this cycle |
| dstAddr | input | 48 | Destination address, byte 0 in bits [7:0] |
| srcAddr | input | 48 | Source address, byte 0 in bits [7:0] |
| etherType | input | 16 | Type field |
| ctrlOpcode | input | 16 | First payload word (control opcode) |
| entryAddr | input | 384 | Station addresses, entry i in bits [48i+47:48i] |
| entryEnable | input | 7 | Enable for entries 1..7 |
| entryIsSrc | input | 7 | Role for entries 1..7: 1 source, 0 destination |
| entryMask | input | 42 | Byte masks for entries 1..7, 6 bits each |
| promisc | input | 1 | Promiscuous mode |
| inverseDa | input | 1 | Inverse destination matching |
| passAllMulti | input | 1 | Pass all group destinations |
| blockBcast | input | 1 | Drop all broadcast frames |
| inverseSa | input | 1 | Inverse source matching |
| saEnforce | input | 1 | Drop frames failing the source filter |
| receiveAll | input | 1 | Forward all frames, keep flags |
| ctrlPolicy | input | 2 | Control-frame forwarding policy |
| decValid | output | 1 | Decision valid strobe |
| forward | output | 1 | 1 forward, 0 drop |
| daFail | output | 1 | Destination filter failed |
| saFail | output | 1 | Source filter failed |

## Verification
On every cycle the assertions check the one-cycle latency and the hold of the outputs. They also check that the decision overrides hold: broadcast blocking, promiscuous forwarding with cleared flags, forwarding in receive-all mode, and dropping control frames under policy 00. A further assertion checks that an exact match on entry 0 is recognised. Byte masking, role selection, the inverse modes, the source-entry condition on `saFail` and the full control policy table depend on particular address values and mode combinations. Only the bench's directed scenarios show those.

// File: rtl/addr_filt_pkg.sv
package addr_filt_pkg;

  localparam logic [15:0] CTRL_ETHERTYPE = 16'h8808;
  localparam logic [15:0] PAUSE_OPCODE   = 16'h0001;

  typedef enum logic [1:0] {
    CTRL_DROP_ALL   = 2'b00,
    CTRL_FWD_NOPAUSE = 2'b01,
    CTRL_FWD_ALL    = 2'b10,
    CTRL_FWD_IFPASS = 2'b11
  } ctrlPolicy_e;

  // Strobes produced by the compare datapath for the decision control
  typedef struct packed {
    logic daHit;     // destination matched an active destination entry
    logic saHit;     // source matched an active source entry
    logic saActive;  // at least one source entry enabled
    logic isMulti;   // group bit of destination set
    logic isBcast;   // destination all ones
    logic isCtrl;    // control frame type
    logic isPause;   // control frame carrying the pause opcode
  } matchFlags_t;

  typedef struct packed {
    logic        promisc;
    logic        inverseDa;
    logic        passAllMulti;
    logic        blockBcast;
    logic        inverseSa;
    logic        saEnforce;
    logic        receiveAll;
    ctrlPolicy_e ctrlPolicy;
  } filtMode_t;

endpackage

// File: rtl/addr_filt_match.sv
module addr_filt_match
  import addr_filt_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_BYTES  = 6
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [ADDR_BYTES*8-1:0]           dstAddr,
  input  logic [ADDR_BYTES*8-1:0]           srcAddr,
  input  logic [15:0]                       etherType,
  input  logic [15:0]                       ctrlOpcode,
  input  logic [NUM_ENTRIES*ADDR_BYTES*8-1:0] entryAddr,
  input  logic [NUM_ENTRIES-2:0]            entryEnable,
  input  logic [NUM_ENTRIES-2:0]            entryIsSrc,
  input  logic [(NUM_ENTRIES-1)*ADDR_BYTES-1:0] entryMask,
  output matchFlags_t                       flags
);

  localparam int ADDR_W = ADDR_BYTES * 8;

  logic [NUM_ENTRIES-1:0] daHitVec;
  logic [NUM_ENTRIES-1:0] saHitVec;
  logic [NUM_ENTRIES-1:0] saEnVec;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
    logic                  en;
    logic                  isSrc;
    logic [ADDR_BYTES-1:0] msk;
    logic [ADDR_W-1:0]     cmpAddr;
    logic [ADDR_W-1:0]     refAddr;
    logic [ADDR_BYTES-1:0] byteOk;
    logic                  hit;

    if (i == 0) begin : g_fixed
      assign en    = 1'b1;
      assign isSrc = 1'b0;
      assign msk   = '0;
    end else begin : g_prog
      assign en    = entryEnable[i-1];
      assign isSrc = entryIsSrc[i-1];
      assign msk   = entryMask[(i-1)*ADDR_BYTES +: ADDR_BYTES];
    end

    assign refAddr = entryAddr[i*ADDR_W +: ADDR_W];
    assign cmpAddr = isSrc ? srcAddr : dstAddr;

    for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_byte
      assign byteOk[b] = msk[b] | (cmpAddr[8*b +: 8] == refAddr[8*b +: 8]);
    end

    assign hit         = en & (&byteOk);
    assign daHitVec[i] = hit & ~isSrc;
    assign saHitVec[i] = hit & isSrc;
    assign saEnVec[i]  = en & isSrc;
  end

  always_comb begin
    flags.daHit    = |daHitVec;
    flags.saHit    = |saHitVec;
    flags.saActive = |saEnVec;
    flags.isMulti  = dstAddr[0];
    flags.isBcast  = &dstAddr;
    flags.isCtrl   = (etherType == CTRL_ETHERTYPE);
    flags.isPause  = (etherType == CTRL_ETHERTYPE) && (ctrlOpcode == PAUSE_OPCODE);
  end

  // R3: an exact destination match on the fixed entry is always recognised
  p_entry0_hit_r3: assert property (@(posedge clk) disable iff (!rstN)
    (dstAddr == entryAddr[ADDR_W-1:0]) |-> flags.daHit);

endmodule

// File: rtl/addr_filt_ctrl.sv
module addr_filt_ctrl
  import addr_filt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hdrValid,
  input  matchFlags_t flags,
  input  filtMode_t   mode,
  output logic        decValid,
  output logic        forward,
  output logic        daFail,
  output logic        saFail
);

  logic daFailRaw;
  logic saFailRaw;
  logic addrOk;
  logic ctrlFwd;
  logic fwdNext;
  logic daFailNext;
  logic saFailNext;

  always_comb begin
    if (flags.isBcast)
      daFailRaw = 1'b0;
    else if (flags.isMulti && mode.passAllMulti)
      daFailRaw = 1'b0;
    else
      daFailRaw = mode.inverseDa ? flags.daHit : ~flags.daHit;

    saFailRaw = flags.saActive & (mode.inverseSa ? flags.saHit : ~flags.saHit);
    addrOk    = ~daFailRaw & ~(mode.saEnforce & saFailRaw);

    unique case (mode.ctrlPolicy)
      CTRL_DROP_ALL:    ctrlFwd = 1'b0;
      CTRL_FWD_NOPAUSE: ctrlFwd = ~flags.isPause;
      CTRL_FWD_ALL:     ctrlFwd = 1'b1;
      default:          ctrlFwd = addrOk;
    endcase

    if (mode.blockBcast && flags.isBcast) fwdNext = 1'b0;
    else if (mode.promisc)                fwdNext = 1'b1;
    else if (mode.receiveAll)             fwdNext = 1'b1;
    else if (flags.isCtrl)                fwdNext = ctrlFwd;
    else                                  fwdNext = addrOk;

    daFailNext = mode.promisc ? 1'b0 : daFailRaw;
    saFailNext = mode.promisc ? 1'b0 : saFailRaw;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decValid <= 1'b0;
      forward  <= 1'b0;
      daFail   <= 1'b0;
      saFail   <= 1'b0;
    end else begin
      decValid <= hdrValid;
      if (hdrValid) begin
        forward <= fwdNext;
        daFail  <= daFailNext;
        saFail  <= saFailNext;
      end
    end
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid |=> decValid);

  p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rstN)
    !hdrValid |=> !decValid && $stable(forward) && $stable(daFail) && $stable(saFail));

  p_promisc_r2: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid && mode.promisc && !(mode.blockBcast && flags.isBcast)
    |=> forward && !daFail && !saFail);

  p_bcast_block_r6: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid && mode.blockBcast && flags.isBcast |=> !forward);

  p_rxall_r9: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid && mode.receiveAll && !(mode.blockBcast && flags.isBcast) |=> forward);

  p_ctrl_drop_r10: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid && flags.isCtrl && mode.ctrlPolicy == CTRL_DROP_ALL
    && !mode.promisc && !mode.receiveAll |=> !forward);

endmodule

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter
  import addr_filt_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_BYTES  = 6
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  hdrValid,
  input  logic [ADDR_BYTES*8-1:0]               dstAddr,
  input  logic [ADDR_BYTES*8-1:0]               srcAddr,
  input  logic [15:0]                           etherType,
  input  logic [15:0]                           ctrlOpcode,
  input  logic [NUM_ENTRIES*ADDR_BYTES*8-1:0]   entryAddr,
  input  logic [NUM_ENTRIES-2:0]                entryEnable,
  input  logic [NUM_ENTRIES-2:0]                entryIsSrc,
  input  logic [(NUM_ENTRIES-1)*ADDR_BYTES-1:0] entryMask,
  input  logic                                  promisc,
  input  logic                                  inverseDa,
  input  logic                                  passAllMulti,
  input  logic                                  blockBcast,
  input  logic                                  inverseSa,
  input  logic                                  saEnforce,
  input  logic                                  receiveAll,
  input  logic [1:0]                            ctrlPolicy,
  output logic                                  decValid,
  output logic                                  forward,
  output logic                                  daFail,
  output logic                                  saFail
);

  matchFlags_t flags;
  filtMode_t   mode;

  always_comb begin
    mode.promisc      = promisc;
    mode.inverseDa    = inverseDa;
    mode.passAllMulti = passAllMulti;
    mode.blockBcast   = blockBcast;
    mode.inverseSa    = inverseSa;
    mode.saEnforce    = saEnforce;
    mode.receiveAll   = receiveAll;
    mode.ctrlPolicy   = ctrlPolicy_e'(ctrlPolicy);
  end

  addr_filt_match #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .ADDR_BYTES (ADDR_BYTES)
  ) u_match (
    .clk        (clk),
    .rstN       (rstN),
    .dstAddr    (dstAddr),
    .srcAddr    (srcAddr),
    .etherType  (etherType),
    .ctrlOpcode (ctrlOpcode),
    .entryAddr  (entryAddr),
    .entryEnable(entryEnable),
    .entryIsSrc (entryIsSrc),
    .entryMask  (entryMask),
    .flags      (flags)
  );

  addr_filt_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .hdrValid(hdrValid),
    .flags   (flags),
    .mode    (mode),
    .decValid(decValid),
    .forward (forward),
    .daFail  (daFail),
    .saFail  (saFail)
  );

endmodule

// File: tb/tb_eth_rx_addr_filter.sv
`timescale 1ns/1ps
module tb_eth_rx_addr_filter;

  localparam logic [47:0] STA   = 48'h0A0B0C0D0E10;
  localparam logic [47:0] OTHER = 48'h0A0B0C0D0E20;
  localparam logic [47:0] MCAST = 48'h0000AB005E01;
  localparam logic [47:0] BCAST = 48'hFFFFFFFFFFFF;
  localparam logic [47:0] E1    = 48'h112233445500;
  localparam logic [47:0] E1ALT = 48'h1122334455FE;
  localparam logic [47:0] SA0   = 48'h0000000000A2;
  localparam logic [47:0] SAX   = 48'h0000000000B4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hdrValid = 1'b0;
  logic [47:0] dstAddr = '0, srcAddr = '0;
  logic [15:0] etherType = 16'h0800, ctrlOpcode = '0;
  logic [383:0] entryAddr = '0;
  logic [6:0] entryEnable = '0, entryIsSrc = '0;
  logic [41:0] entryMask = '0;
  logic promisc = 0, inverseDa = 0, passAllMulti = 0, blockBcast = 0;
  logic inverseSa = 0, saEnforce = 0, receiveAll = 0;
  logic [1:0] ctrlPolicy = 2'b00;
  logic decValid, forward, daFail, saFail;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  eth_rx_addr_filter dut (
    .clk(clk), .rstN(rstN), .hdrValid(hdrValid), .dstAddr(dstAddr), .srcAddr(srcAddr),
    .etherType(etherType), .ctrlOpcode(ctrlOpcode), .entryAddr(entryAddr),
    .entryEnable(entryEnable), .entryIsSrc(entryIsSrc), .entryMask(entryMask),
    .promisc(promisc), .inverseDa(inverseDa), .passAllMulti(passAllMulti),
    .blockBcast(blockBcast), .inverseSa(inverseSa), .saEnforce(saEnforce),
    .receiveAll(receiveAll), .ctrlPolicy(ctrlPolicy), .decValid(decValid),
    .forward(forward), .daFail(daFail), .saFail(saFail));

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: {valid,fwd,daFail,saFail} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic clearCfg();
    promisc = 0; inverseDa = 0; passAllMulti = 0; blockBcast = 0;
    inverseSa = 0; saEnforce = 0; receiveAll = 0; ctrlPolicy = 2'b00;
    entryEnable = '0; entryIsSrc = '0; entryMask = '0;
    entryAddr = '0;
    entryAddr[47:0] = STA;
  endtask

  task automatic frame(string req, logic [47:0] da, logic [47:0] sa, logic [15:0] typ,
                       logic [15:0] op, logic fwd, logic daF, logic saF);
    @(negedge clk);
    dstAddr = da; srcAddr = sa; etherType = typ; ctrlOpcode = op; hdrValid = 1'b1;
    @(negedge clk);
    hdrValid = 1'b0;
    check(req, {decValid, forward, daFail, saFail}, {1'b1, fwd, daF, saF});
  endtask

  task automatic testReset();
    check("R1 reset", {decValid, forward, daFail, saFail}, 4'b0000);
  endtask

  task automatic testLatency();
    clearCfg();
    frame("R1 R3 station unicast", STA, SAX, 16'h0800, 16'h0, 1, 0, 0);
    @(negedge clk);
    check("R1 hold after strobe", {decValid, forward, daFail, saFail}, 4'b0100);
    dstAddr = OTHER;
    @(negedge clk);
    check("R1 no strobe without valid", {decValid, forward, daFail, saFail}, 4'b0100);
  endtask

  task automatic testDaMatch();
    clearCfg();
    frame("R3 mismatch", OTHER, SAX, 16'h0800, 16'h0, 0, 1, 0);
    entryAddr[95:48] = E1; entryEnable[0] = 1'b1;
    frame("R3 unmasked byte0 differs", E1ALT, SAX, 16'h0800, 16'h0, 0, 1, 0);
    entryMask[0] = 1'b1;
    frame("R3 masked byte0", E1ALT, SAX, 16'h0800, 16'h0, 1, 0, 0);
    entryIsSrc[0] = 1'b1;
    frame("R3 entry in source role", E1ALT, SAX, 16'h0800, 16'h0, 0, 1, 1);
  endtask

  task automatic testInverseDa();
    clearCfg(); inverseDa = 1;
    frame("R4 inverse match fails", STA, SAX, 16'h0800, 16'h0, 0, 1, 0);
    frame("R4 inverse other passes", OTHER, SAX, 16'h0800, 16'h0, 1, 0, 0);
    frame("R4 inverse multicast passes", MCAST, SAX, 16'h0800, 16'h0, 1, 0, 0);
  endtask

  task automatic testMulticast();
    clearCfg();
    frame("R5 multicast without pass-all", MCAST, SAX, 16'h0800, 16'h0, 0, 1, 0);
    passAllMulti = 1;
    frame("R5 multicast pass-all", MCAST, SAX, 16'h0800, 16'h0, 1, 0, 0);
    passAllMulti = 0;
    frame("R5 broadcast passes", BCAST, SAX, 16'h0800, 16'h0, 1, 0, 0);
  endtask

  task automatic testBcastBlock();
    clearCfg(); blockBcast = 1;
    frame("R6 broadcast blocked", BCAST, SAX, 16'h0800, 16'h0, 0, 0, 0);
    promisc = 1; receiveAll = 1; ctrlPolicy = 2'b10;
    frame("R6 overrides promisc and receive-all", BCAST, SAX, 16'h8808, 16'h0001, 0, 0, 0);
    frame("R6 unicast unaffected", OTHER, SAX, 16'h0800, 16'h0, 1, 0, 0);
  endtask

  task automatic testSourceFilter();
    clearCfg();
    entryAddr[143:96] = SA0; entryEnable[1] = 1'b1; entryIsSrc[1] = 1'b1;
    frame("R7 source matches", STA, SA0, 16'h0800, 16'h0, 1, 0, 0);
    frame("R7 R8 source mismatch not enforced", STA, SAX, 16'h0800, 16'h0, 1, 0, 1);
    saEnforce = 1;
    frame("R8 source mismatch enforced", STA, SAX, 16'h0800, 16'h0, 0, 0, 1);
    saEnforce = 0; inverseSa = 1;
    frame("R7 inverse source match fails", STA, SA0, 16'h0800, 16'h0, 1, 0, 1);
    frame("R7 inverse source other passes", STA, SAX, 16'h0800, 16'h0, 1, 0, 0);
  endtask

  task automatic testReceiveAll();
    clearCfg();
    entryAddr[143:96] = SA0; entryEnable[1] = 1'b1; entryIsSrc[1] = 1'b1;
    receiveAll = 1; saEnforce = 1;
    frame("R9 both fail still forwarded", OTHER, SAX, 16'h0800, 16'h0, 1, 1, 1);
    frame("R9 da fail only", OTHER, SA0, 16'h0800, 16'h0, 1, 1, 0);
  endtask

  task automatic testPromisc();
    clearCfg();
    entryAddr[143:96] = SA0; entryEnable[1] = 1'b1; entryIsSrc[1] = 1'b1;
    promisc = 1; saEnforce = 1;
    frame("R2 promisc forwards, flags cleared", OTHER, SAX, 16'h0800, 16'h0, 1, 0, 0);
  endtask

  task automatic testControl();
    clearCfg();
    ctrlPolicy = 2'b00;
    frame("R10 policy 00 pause dropped", STA, SAX, 16'h8808, 16'h0001, 0, 0, 0);
    frame("R10 policy 00 ordinary type", STA, SAX, 16'h0800, 16'h0001, 1, 0, 0);
    ctrlPolicy = 2'b01;
    frame("R10 policy 01 non-pause failing", OTHER, SAX, 16'h8808, 16'h0002, 1, 1, 0);
    frame("R10 policy 01 pause failing", OTHER, SAX, 16'h8808, 16'h0001, 0, 1, 0);
    frame("R10 policy 01 pause passing", STA, SAX, 16'h8808, 16'h0001, 0, 0, 0);
    ctrlPolicy = 2'b10;
    frame("R10 policy 10 pause failing", OTHER, SAX, 16'h8808, 16'h0001, 1, 1, 0);
    ctrlPolicy = 2'b11;
    frame("R10 policy 11 failing", OTHER, SAX, 16'h8808, 16'h0001, 0, 1, 0);
    frame("R10 policy 11 passing", STA, SAX, 16'h8808, 16'h0001, 1, 0, 0);
  endtask

  initial begin
    clearCfg();
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLatency();
    testDaMatch();
    testInverseDa();
    testMulticast();
    testBcastBlock();
    testSourceFilter();
    testReceiveAll();
    testPromisc();
    testControl();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule